// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a single-cycle register bus. Each counter is advanced by its own tick source. The source is either a divided copy of the bus clock, through a power-of-two prescaler, or a single-cycle reference pulse supplied by the surrounding chip. One shared control word holds the settings for both counters. One shared status word holds both expiry flags.

Software loads a counter by writing its value register and sets a reload value. It then selects either periodic operation, where the counter reloads on expiry, or one-shot operation, where the counter parks at zero. A counter reloading from all ones runs freely, and the bit-inverse of its value serves as an up-counting timestamp. Each counter drives a level interrupt. The interrupt is raised while that counter's expiry flag is set and the counter is enabled. Software clears a flag by writing zero to its bit.

Top module: `dual_dntimer`

## Requirements
- R1: After reset every register reads as zero and both interrupt outputs are low.
- R2: The control word at offset 0x00 holds the following fields: timer 0 enable at bit 0 and periodic mode at bit 1; timer 1 enable at bit 2 and periodic mode at bit 3; reference-pulse select at bit 11 (timer 0) and bit 12 (timer 1); a 3-bit prescaler field at bits 21:19 (timer 0) and bits 24:22 (timer 1). All other bits read as zero. A disabled counter holds its value.
- R3: With reference select clear and a prescaler field of N, the counter decrements once every 2^N bus clocks. The first decrement falls in the 2^N-th cycle after the enabling write. The divider restarts when the timer is disabled or when a control write changes its field.
- R4: With reference select set, an enabled counter decrements once per cycle in which `ref_tick` is high. The prescaler plays no part.
- R5: Reload registers sit at 0x10 (timer 0) and 0x18 (timer 1). Value registers sit at 0x14 and 0x1C. A value write loads the counter directly and takes priority over a tick in the same cycle. Reads return the current contents.
- R6: In periodic mode, a tick taken at zero sets the flag and reloads the counter. Loading P into both reload and value therefore gives an expiry every P+1 ticks.
- R7: In one-shot mode, a tick taken at zero sets the flag and leaves the counter at zero. No further tick is taken until the next control write or value write to that timer.
- R8: The status word at 0x04 holds the timer 0 flag at bit 0 and the timer 1 flag at bit 8. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. An expiry in the same cycle as a clearing write keeps the flag set.
- R9: `irq[i]` is high exactly while flag i and enable i are both set, and it holds until one of them is cleared.
- R10: A periodic counter with reload 0xFFFFFFFF that expires from zero continues at 0xFFFFFFFF and then keeps decrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | Single-cycle reference pulse, synchronous to clk |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| irq | output | 2 | Level interrupt per timer |

## Verification
A write is sampled at the rising edge that ends its cycle. The new register, counter, flag and interrupt values are therefore visible after that edge, and read data follows the address in the same cycle. A tick changes the counter at the edge that ends the tick cycle, so an expiry flag and its interrupt appear P+1 ticks after the enabling edge. With prescaler N, that is 2^N cycles per tick. The bench drives inputs just after the falling edge and advances a behavioural model on each rising edge. At every falling edge it compares both interrupts and the read data of the addressed register. Directed checks count falling edges from the enabling write to the interrupt against these latencies.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int NT          = 2;
  localparam int DIV_W       = 3;
  localparam int EN_STRIDE   = 2;
  localparam int REF_BASE    = 11;
  localparam int DIV_BASE    = 19;
  localparam int FLAG_STRIDE = 8;
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_STAT    = 'h04;
  localparam int OFS_RLD     = 'h10;
  localparam int OFS_VAL     = 'h14;
  localparam int OFS_STRIDE  = 'h08;
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ref_sel,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = (1 << DIV_W) - 1;

  logic [CW-1:0] pc_q, pc_d, mask;
  logic          at_end, pc_en;

  always_comb begin
    mask   = ~({CW{1'b1}} << div);
    at_end = (pc_q == mask);
    tick   = run && (ref_sel ? ref_tick : at_end);
    if (restart || !run || ref_sel || at_end) pc_d = '0;
    else                                     pc_d = pc_q + CW'(1);
    pc_en  = (pc_d != pc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reload_mode,
  input  logic          val_wr,
  input  logic          rld_wr,
  input  logic          clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          flag_o,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q, cnt_d, rld_q;
  logic          flag_q, flag_d, cnt_en;

  always_comb begin
    expire_o = tick && !val_wr && (cnt_q == '0);
    cnt_en   = val_wr || tick;
    if (val_wr)        cnt_d = wdata;
    else if (expire_o) cnt_d = reload_mode ? rld_q : '0;
    else               cnt_d = cnt_q - DW'(1);
    if (expire_o)      flag_d = 1'b1;
    else if (clr)      flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rld_wr) rld_q <= wdata;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer
  import dtmr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NT-1:0]     irq
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic ctrl_wr, stat_wr;
  logic [NT-1:0] en_q, en_d, rm_q, rm_d, ref_q, ref_d, halt_q, halt_d;
  logic [NT-1:0] tick, expire, flag, val_wr, rld_wr, clr, restart, run;
  logic [NT-1:0][DIV_W-1:0] div_q, div_d, wdiv;
  logic [NT-1:0][DW-1:0]    cnt, rld;

  always_comb begin
    ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    stat_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    for (int i = 0; i < NT; i++) begin
      val_wr[i]  = bus_wr && (bus_addr == ADDR_W'(OFS_VAL + OFS_STRIDE * i));
      rld_wr[i]  = bus_wr && (bus_addr == ADDR_W'(OFS_RLD + OFS_STRIDE * i));
      clr[i]     = stat_wr && !bus_wdata[FLAG_STRIDE * i];
      wdiv[i]    = bus_wdata[DIV_BASE + DIV_W * i +: DIV_W];
      restart[i] = ctrl_wr && (wdiv[i] != div_q[i]);
      run[i]     = en_q[i] && !halt_q[i];
      en_d[i]    = en_q[i];
      rm_d[i]    = rm_q[i];
      ref_d[i]   = ref_q[i];
      div_d[i]   = div_q[i];
      halt_d[i]  = halt_q[i];
      if (ctrl_wr) begin
        en_d[i]  = bus_wdata[EN_STRIDE * i];
        rm_d[i]  = bus_wdata[EN_STRIDE * i + 1];
        ref_d[i] = bus_wdata[REF_BASE + i];
        div_d[i] = wdiv[i];
      end
      if (ctrl_wr || val_wr[i])         halt_d[i] = 1'b0;
      else if (expire[i] && !rm_q[i])   halt_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= '0;
    end else if (!rst_core_n) begin
      halt_q <= '0;
    end else begin
      halt_q <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q  <= '0;
      rm_q  <= '0;
      ref_q <= '0;
      div_q <= '0;
    end else if (ctrl_wr || (en_d != en_q)) begin
      en_q  <= en_d;
      rm_q  <= rm_d;
      ref_q <= ref_d;
      div_q <= div_d;
    end
  end

  for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
    dtmr_prescale #(.DIV_W(DIV_W)) u_psc (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .run      (run[gi]),
      .restart  (restart[gi]),
      .ref_sel  (ref_q[gi]),
      .ref_tick (ref_tick),
      .div      (div_q[gi]),
      .tick     (tick[gi])
    );

    dtmr_channel #(.DW(DW)) u_chn (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .tick        (tick[gi]),
      .reload_mode (rm_q[gi]),
      .val_wr      (val_wr[gi]),
      .rld_wr      (rld_wr[gi]),
      .clr         (clr[gi]),
      .wdata       (bus_wdata),
      .cnt_o       (cnt[gi]),
      .rld_o       (rld[gi]),
      .flag_o      (flag[gi]),
      .expire_o    (expire[gi])
    );

    assign irq[gi] = flag[gi] & en_q[gi];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      for (int i = 0; i < NT; i++) begin
        bus_rdata[EN_STRIDE * i]                = en_q[i];
        bus_rdata[EN_STRIDE * i + 1]            = rm_q[i];
        bus_rdata[REF_BASE + i]                 = ref_q[i];
        bus_rdata[DIV_BASE + DIV_W * i +: DIV_W] = div_q[i];
      end
    end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
      for (int i = 0; i < NT; i++) bus_rdata[FLAG_STRIDE * i] = flag[i];
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (bus_addr == ADDR_W'(OFS_RLD + OFS_STRIDE * i)) bus_rdata = rld[i];
        if (bus_addr == ADDR_W'(OFS_VAL + OFS_STRIDE * i)) bus_rdata = cnt[i];
      end
    end
  end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int NT = 2,
  parameter int DW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NT-1:0]       tick,
  input logic [NT-1:0][DW-1:0] cnt,
  input logic [NT-1:0][DW-1:0] rld,
  input logic [NT-1:0]       flag,
  input logic [NT-1:0]       en,
  input logic [NT-1:0]       rm,
  input logic [NT-1:0]       val_wr,
  input logic                ctrl_wr,
  input logic                stat_wr,
  input logic [NT-1:0]       irq
);
  for (genvar gi = 0; gi < NT; gi++) begin : g_chk
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[gi] && cnt[gi] != '0 && !val_wr[gi]) |=> (cnt[gi] == $past(cnt[gi]) - DW'(1)));
    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[gi] && cnt[gi] == '0 && rm[gi] && !val_wr[gi]) |=> (cnt[gi] == $past(rld[gi])));
    // R7
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[gi] && cnt[gi] == '0 && !rm[gi] && !val_wr[gi] && !ctrl_wr) |=> (cnt[gi] == '0 && !tick[gi]));
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[gi] && cnt[gi] == '0 && !val_wr[gi]) |=> flag[gi]);
    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[gi] && !ctrl_wr && !stat_wr) |=> irq[gi]);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[gi] && !val_wr[gi]) |=> $stable(cnt[gi]));
  end
endmodule

bind dual_dntimer dtmr_chk #(.NT(dtmr_pkg::NT), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .tick    (tick),
  .cnt     (cnt),
  .rld     (rld),
  .flag    (flag),
  .en      (en_q),
  .rm      (rm_q),
  .val_wr  (val_wr),
  .ctrl_wr (ctrl_wr),
  .stat_wr (stat_wr),
  .irq     (irq)
);

// File: tb/dual_dntimer_test.sv
`timescale 1ns/1ps
module dual_dntimer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_ref = 1'b0;
  logic        b_wr = 1'b0;
  logic [7:0]  b_addr = 8'h00;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_dntimer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(b_ref), .bus_wr(b_wr),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata), .irq(irq)
  );

  bit [31:0] m_cnt[2], m_rel[2];
  bit        m_en[2], m_rm[2], m_rs[2], m_flag[2], m_halt[2];
  int        m_div[2], m_pc[2];

  initial for (int i = 0; i < 2; i++) begin
    m_cnt[i] = 0; m_rel[i] = 0; m_en[i] = 0; m_rm[i] = 0; m_rs[i] = 0;
    m_flag[i] = 0; m_halt[i] = 0; m_div[i] = 0; m_pc[i] = 0;
  end

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      bit cw, vw, rw, run, tk, ex, rs;
      int mask, nd;
      if (!rst_n) begin
        m_cnt[i] = 0; m_rel[i] = 0; m_en[i] = 0; m_rm[i] = 0; m_rs[i] = 0;
        m_flag[i] = 0; m_halt[i] = 0; m_div[i] = 0; m_pc[i] = 0;
      end else begin
        cw   = b_wr && b_addr == 8'h00;
        vw   = b_wr && b_addr == 8'(20 + 8 * i);
        rw   = b_wr && b_addr == 8'(16 + 8 * i);
        mask = (1 << m_div[i]) - 1;
        run  = m_en[i] && !m_halt[i];
        tk   = run && (m_rs[i] ? b_ref : (m_pc[i] == mask));
        ex   = tk && !vw && m_cnt[i] == 0;
        nd   = int'((b_wdata >> (19 + 3 * i)) & 32'h7);
        rs   = cw && nd != m_div[i];
        m_pc[i] = (rs || !run || m_rs[i] || m_pc[i] == mask) ? 0 : m_pc[i] + 1;
        if (vw)      m_cnt[i] = b_wdata;
        else if (ex) m_cnt[i] = m_rm[i] ? m_rel[i] : 0;
        else if (tk) m_cnt[i] = m_cnt[i] - 1;
        if (rw) m_rel[i] = b_wdata;
        if (ex) m_flag[i] = 1;
        else if (b_wr && b_addr == 8'h04 && !b_wdata[8 * i]) m_flag[i] = 0;
        if (cw || vw)          m_halt[i] = 0;
        else if (ex && !m_rm[i]) m_halt[i] = 1;
        if (cw) begin
          m_en[i]  = b_wdata[2 * i];
          m_rm[i]  = b_wdata[2 * i + 1];
          m_rs[i]  = b_wdata[11 + i];
          m_div[i] = nd;
        end
      end
    end
  end

  function automatic bit [31:0] mread(bit [7:0] a);
    bit [31:0] v = 0;
    case (a)
      8'h00: for (int i = 0; i < 2; i++) begin
        v[2 * i] = m_en[i]; v[2 * i + 1] = m_rm[i]; v[11 + i] = m_rs[i];
        v = v | (32'(m_div[i]) << (19 + 3 * i));
      end
      8'h04: begin v[0] = m_flag[0]; v[8] = m_flag[1]; end
      8'h10: v = m_rel[0];
      8'h14: v = m_cnt[0];
      8'h18: v = m_rel[1];
      8'h1C: v = m_cnt[1];
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R9 irq level", {30'd0, irq}, {30'd0, m_flag[1] & m_en[1], m_flag[0] & m_en[0]});
    chk("R5 read data", rdata, mread(b_addr));
  end

  task automatic wr(bit [7:0] a, bit [31:0] d);
    @(negedge clk); #1; b_wr = 1; b_addr = a; b_wdata = d;
    @(negedge clk); #1; b_wr = 0;
  endtask

  task automatic rd(bit [7:0] a, output logic [31:0] d);
    @(negedge clk); #1; b_addr = a; #1; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); #1; b_ref = 1;
    @(negedge clk); #1; b_ref = 0;
  endtask

  task automatic wait_irq(int idx, output int n);
    n = 0;
    while (irq[idx] !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 stat", v, 0);
    rd(8'h1C, v); chk("R1 val1", v, 0);
    chk("R1 irq", {30'd0, irq}, 0);
    // R2 control layout
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 ctrl bits", v, 32'h01F8_180F);
    wr(8'h00, 0); wr(8'h04, 0);
    // R5 registers
    wr(8'h10, 3); wr(8'h14, 3); wr(8'h18, 32'h0000_A5A5);
    rd(8'h14, v); chk("R5 val0", v, 3);
    rd(8'h18, v); chk("R5 rld1", v, 32'h0000_A5A5);
    // R6 periodic P=3 -> 4 ticks
    wr(8'h00, 32'h3);
    wait_irq(0, n); chk("R6 period", n, 4);
    repeat (12) @(negedge clk);
    wr(8'h00, 0); wr(8'h04, 0);
    // R3 prescale 4, one-shot from 1 -> expiry after 8 cycles
    wr(8'h14, 1); wr(8'h00, 32'h1 | (2 << 19));
    wait_irq(0, n); chk("R3 prescale", n, 8);
    repeat (20) @(negedge clk);
    rd(8'h14, v); chk("R7 parked", v, 0);
    chk("R9 hold", {31'd0, irq[0]}, 1);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R8 write one keeps", v, 1);
    wr(8'h04, 0);
    rd(8'h04, v); chk("R8 write zero clears", v, 0);
    chk("R9 drop", {31'd0, irq[0]}, 0);
    // R3 restart on field change mid-run
    wr(8'h14, 40); wr(8'h00, 32'h3 | (1 << 19));
    repeat (5) @(negedge clk);
    wr(8'h00, 32'h3 | (3 << 19));
    repeat (30) @(negedge clk);
    wr(8'h00, 0); wr(8'h04, 0);
    // R4 reference pulses on timer 1
    wr(8'h1C, 2); wr(8'h00, 32'h1004);
    repeat (10) @(negedge clk);
    rd(8'h1C, v); chk("R4 no pulse", v, 2);
    pulse();
    rd(8'h1C, v); chk("R4 one pulse", v, 1);
    pulse(); pulse();
    @(negedge clk);
    chk("R4 expiry", {31'd0, irq[1]}, 1);
    // R10 wrap from zero to all ones
    wr(8'h00, 0);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 0); wr(8'h00, 32'h3);
    rd(8'h14, v); chk("R10 wrap", v, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R10 next", v, 32'hFFFF_FFFE);
    // R8 expiry wins against a clear in the same cycle
    wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h04, 0);
    rd(8'h04, v); chk("R8 expiry wins", v, 32'h0000_0001);
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, v); chk("R8 clear timer1 only", v, 32'h0000_0001);
    wr(8'h00, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule